// File: doc/BRIEF.md
# Active/Sleep Power Mode Controller

This block holds the power mode of a battery-pack monitor: sleep, where measurement and protection pause, or active. Each clock cycle it weighs a set of wake causes against a set of sleep causes. The wake causes are a power-switch pin pulled low, a charger detected on the pack terminal, the host data line going high, and a swap command. The sleep causes are a host data line held low for two seconds, an undervoltage request, and a swap command. Two control bits gate these causes. One enables the data-line rules. The other hands mode control to the swap command.

The two-second data-line timer counts pulses of an external tick of known rate. The rate is a parameter, so the timeout does not depend on the core clock frequency. The power-switch and data-line pins are asynchronous and each passes through a two-flop synchroniser. In sleep, and only while swap control is off, the block requests a pull-down on the pack terminal. This drains stray charge so that a real charger can be told apart.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Reset puts the block in sleep: `active_o` = 0 while `rst_n` is low and after reset is released.
- R2: With `pmod_i` = 1, a synchronised data line that stays low for `TICKS_PER_SEC*TIMEOUT_SEC` tick pulses puts an active block to sleep on the clock edge after the last counted tick. One tick fewer leaves it active.
- R3: With `pmod_i` = 0, a data line held low for any number of ticks does not end active mode.
- R4: The data-line timer restarts from zero whenever the synchronised data line is high. Two low spells, each one tick short of the limit and separated by a high spell, do not cause sleep.
- R5: An `uv_sleep_i` pulse moves an active block to sleep on the next edge when no wake cause is present.
- R6: With `swen_i` = 1, a `swap_i` pulse toggles the mode on the next edge (sleep to active, active to sleep). With `swen_i` = 0, `swap_i` has no effect.
- R7: With `pmod_i` = 1 and `swen_i` = 0, a high data line wakes the block. With `pmod_i` = 0 or `swen_i` = 1, a high data line does not wake it.
- R8: A low level on `ps_n_i` wakes the block whatever the control bits are. The block stays active after the pin is released.
- R9: `chg_det_i` = 1 wakes the block when `swen_i` = 0. It has no effect when `swen_i` = 1.
- R10: When a wake cause and a sleep cause are present in the same cycle, the block is active on the next edge.
- R11: `pls_pd_o` is 1 exactly when the block is asleep and `swen_i` = 0. It follows `swen_i` in the same cycle.
- R12: `ps_n_i` and `dq_i` act on the third rising edge after they change. `chg_det_i`, `uv_sleep_i` and `swap_i` act on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse at TICKS_PER_SEC per second |
| dq_i | input | 1 | Host data line level, asynchronous |
| ps_n_i | input | 1 | Power-switch pin, low = pressed, asynchronous |
| chg_det_i | input | 1 | Pack terminal above cell voltage (charger present), synchronous |
| uv_sleep_i | input | 1 | Undervoltage sleep request, synchronous |
| pmod_i | input | 1 | Enables the data-line sleep and wake rules |
| swen_i | input | 1 | Gives mode control to the swap command |
| swap_i | input | 1 | Swap command strobe, one cycle |
| active_o | output | 1 | 1 = active mode, 0 = sleep |
| pls_pd_o | output | 1 | Pack-terminal pull-down enable |

## Verification
The assertions check on every cycle that each enabled wake cause results in active mode on the next edge. They also check that a sleep cause with no competing wake cause results in sleep, that a high synchronised data line clears the timeout, and that the pull-down is never on while the block is active. Only the bench scenarios can show the exact count of ticks before timeout, the restart of the timer across several low spells, the three-edge latency of the synchronised pins, and that gated-off causes leave the mode unchanged over long stretches.

// File: rtl/pmc_pkg.sv
// Package: shared mode encoding for the power mode controller.
// Assumes: a single-bit mode, where 1 means active.
package pmc_pkg;
    typedef enum logic {
        MODE_SLEEP  = 1'b0,
        MODE_ACTIVE = 1'b1
    } pmc_mode_e;
endpackage

// File: rtl/pmc_sync.sv
// Module: pmc_sync
// A bank of W independent two-flop synchronisers. Each bit has its own reset
// value, so that an inactive level can be presented during reset.
// Assumes: the inputs are quasi-static compared with clk; no glitch filtering.
module pmc_sync #(
    parameter int         W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        logic meta_q;
        logic sync_q;
        // Two-stage capture of one asynchronous bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[gi];
                sync_q <= RST_VAL[gi];
            end else begin
                meta_q <= d_i[gi];
                sync_q <= meta_q;
            end
        end
        assign q_o[gi] = sync_q;
    end
endmodule

// File: rtl/pmc_idle_timer.sv
// Module: pmc_idle_timer
// Counts tick pulses while the synchronised data line is low. The count
// saturates at LIMIT, and tmo_o is raised once LIMIT ticks have been counted.
// A high line clears the count at once.
// Assumes: tick_i is a single-cycle pulse.
module pmc_idle_timer #(
    parameter int TICKS_PER_SEC = 32,
    parameter int TIMEOUT_SEC   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic line_hi_i,
    output logic tmo_o
);
    localparam int LIMIT = TICKS_PER_SEC * TIMEOUT_SEC;
    localparam int CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Low-time counter: clears on a high line, otherwise counts ticks up to LIMIT
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (line_hi_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != LIMIT_C)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Timeout flag taken straight from the saturated count
    always_comb tmo_o = (cnt_q == LIMIT_C);
endmodule

// File: rtl/pmc_mode_fsm.sv
// Module: pmc_mode_fsm
// Holds the mode register. It gathers the gated wake and sleep causes and
// applies them with wake first, so that any wake cause beats any sleep cause.
// Assumes: every input is synchronous to clk.
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dq_hi_i,
    input  logic ps_low_i,
    input  logic chg_det_i,
    input  logic uv_sleep_i,
    input  logic tmo_i,
    input  logic pmod_i,
    input  logic swen_i,
    input  logic swap_i,
    output logic wake_any_o,
    output logic sleep_any_o,
    output pmc_mode_e mode_o
);
    pmc_mode_e mode_q;
    logic      swap_cmd;

    // Swap strobe is honoured only while swap control is enabled
    always_comb swap_cmd = swap_i && swen_i;

    // Wake causes, each gated by its control bits
    always_comb begin
        wake_any_o = ps_low_i
                   | (chg_det_i && !swen_i)
                   | (pmod_i && !swen_i && dq_hi_i)
                   | (swap_cmd && (mode_q == MODE_SLEEP));
    end

    // Sleep causes, each gated by its control bits
    always_comb begin
        sleep_any_o = uv_sleep_i
                    | (pmod_i && tmo_i)
                    | (swap_cmd && (mode_q == MODE_ACTIVE));
    end

    // Mode register: sleep out of reset, wake has priority over sleep
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_SLEEP;
        end else if (wake_any_o) begin
            mode_q <= MODE_ACTIVE;
        end else if (sleep_any_o) begin
            mode_q <= MODE_SLEEP;
        end
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
// Module: pwr_mode_ctrl (top)
// Active/sleep mode controller for a battery monitor. It synchronises the
// power-switch and data-line pins, times data-line low periods against a
// tick, decides the mode, and drives the pack-terminal pull-down in sleep.
// Assumes: tick_i, chg_det_i, uv_sleep_i and swap_i are synchronous to clk.
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32,
    parameter int TIMEOUT_SEC   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic dq_i,
    input  logic ps_n_i,
    input  logic chg_det_i,
    input  logic uv_sleep_i,
    input  logic pmod_i,
    input  logic swen_i,
    input  logic swap_i,
    output logic active_o,
    output logic pls_pd_o
);
    // Bit 0 = data line (reset low), bit 1 = power switch (reset released)
    localparam int          NSYNC    = 2;
    localparam logic [1:0]  SYNC_RST = 2'b10;

    logic [NSYNC-1:0] raw_pins;
    logic [NSYNC-1:0] sync_pins;
    logic             dq_s;
    logic             ps_s;
    logic             tmo;
    logic             wake_any;
    logic             sleep_any;
    pmc_mode_e        mode;

    assign raw_pins = {ps_n_i, dq_i};

    pmc_sync #(
        .W       (NSYNC),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_pins),
        .q_o   (sync_pins)
    );

    assign dq_s = sync_pins[0];
    assign ps_s = sync_pins[1];

    pmc_idle_timer #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .TIMEOUT_SEC   (TIMEOUT_SEC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .line_hi_i (dq_s),
        .tmo_o     (tmo)
    );

    pmc_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .dq_hi_i     (dq_s),
        .ps_low_i    (!ps_s),
        .chg_det_i   (chg_det_i),
        .uv_sleep_i  (uv_sleep_i),
        .tmo_i       (tmo),
        .pmod_i      (pmod_i),
        .swen_i      (swen_i),
        .swap_i      (swap_i),
        .wake_any_o  (wake_any),
        .sleep_any_o (sleep_any),
        .mode_o      (mode)
    );

    // Output decode: mode flag, and pull-down only in sleep without swap control
    always_comb begin
        active_o = (mode == MODE_ACTIVE);
        pls_pd_o = (mode == MODE_SLEEP) && !swen_i;
    end
endmodule

// File: rtl/pmc_checker.sv
// Module: pmc_checker
// Clocked properties for pwr_mode_ctrl, attached through bind below.
// Assumes: it sees the top's ports and its internal nets dq_s, ps_s, tmo and wake_any.
module pmc_checker (
    input logic clk,
    input logic rst_n,
    input logic pmod_i,
    input logic swen_i,
    input logic swap_i,
    input logic chg_det_i,
    input logic uv_sleep_i,
    input logic active_o,
    input logic pls_pd_o,
    input logic dq_s,
    input logic ps_s,
    input logic tmo,
    input logic wake_any
);
    // R1
    p_reset_sleep_r1: assert property (@(posedge clk)
        !rst_n |=> !active_o);
    // R2
    p_timeout_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && pmod_i && tmo && !wake_any) |=> !active_o);
    // R3
    p_no_pmod_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !pmod_i && !uv_sleep_i && !(swap_i && swen_i)) |=> active_o);
    // R4
    p_timer_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_s |=> !tmo);
    // R5
    p_uv_sleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_sleep_i && !wake_any) |=> !active_o);
    // R6
    p_swap_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_i && swen_i && !active_o) |=> active_o);
    // R6
    p_swap_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_i && !swen_i && !active_o && !wake_any) |=> !active_o);
    // R7
    p_dq_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pmod_i && !swen_i && dq_s) |=> active_o);
    // R8
    p_ps_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ps_s |=> active_o);
    // R9
    p_chg_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_det_i && !swen_i) |=> active_o);
    // R10
    p_wake_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_any |=> active_o);
    // R11
    p_pulldown_sleep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pls_pd_o |-> (!active_o && !swen_i));
endmodule

bind pwr_mode_ctrl pmc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pmod_i     (pmod_i),
    .swen_i     (swen_i),
    .swap_i     (swap_i),
    .chg_det_i  (chg_det_i),
    .uv_sleep_i (uv_sleep_i),
    .active_o   (active_o),
    .pls_pd_o   (pls_pd_o),
    .dq_s       (dq_s),
    .ps_s       (ps_s),
    .tmo        (tmo),
    .wake_any   (wake_any)
);

// File: tb/sim_pwr_mode_ctrl.sv
// Directed bench for pwr_mode_ctrl: one task per scenario, each checking its own results.
module sim_pwr_mode_ctrl;
    localparam int TPS   = 4;
    localparam int TSEC  = 2;
    localparam int LIMIT = TPS * TSEC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, dq = 1'b0, ps_n = 1'b1, chg = 1'b0, uv = 1'b0;
    logic pmod = 1'b0, swen = 1'b0, swap = 1'b0;
    logic active, pls_pd;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwr_mode_ctrl #(.TICKS_PER_SEC(TPS), .TIMEOUT_SEC(TSEC)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .dq_i(dq), .ps_n_i(ps_n),
        .chg_det_i(chg), .uv_sleep_i(uv), .pmod_i(pmod), .swen_i(swen),
        .swap_i(swap), .active_o(active), .pls_pd_o(pls_pd)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input logic act, input logic exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; step(1);
            tick = 1'b0; step(1);
        end
    endtask

    task automatic go_sleep();
        uv = 1'b1; step(1);
        uv = 1'b0; step(1);
    endtask

    task automatic go_active();
        ps_n = 1'b0; step(3);
        ps_n = 1'b1; step(3);
    endtask

    task automatic t_reset();
        step(2);
        check(active, 1'b0, "R1", "active during reset");
        rst_n = 1'b1; step(2);
        check(active, 1'b0, "R1", "active after reset");
        check(pls_pd, 1'b1, "R11", "pull-down in sleep, swen=0");
    endtask

    task automatic t_ps_wake();
        ps_n = 1'b0; step(2);
        check(active, 1'b0, "R12", "ps after two edges");
        step(1);
        check(active, 1'b1, "R12", "ps after three edges");
        check(pls_pd, 1'b0, "R11", "no pull-down when active");
        ps_n = 1'b1; step(4);
        check(active, 1'b1, "R8", "stays active after release");
        go_sleep();
        swen = 1'b1; ps_n = 1'b0; step(3);
        check(active, 1'b1, "R8", "ps wakes with swen=1");
        ps_n = 1'b1; swen = 1'b0; step(3);
    endtask

    task automatic t_chg();
        go_sleep();
        swen = 1'b1; chg = 1'b1; step(3);
        check(active, 1'b0, "R9", "charger ignored with swen=1");
        check(pls_pd, 1'b0, "R11", "no pull-down with swen=1");
        swen = 1'b0; #1;
        check(pls_pd, 1'b1, "R11", "pull-down follows swen");
        step(1);
        check(active, 1'b1, "R12", "charger wakes on next edge");
        chg = 1'b0; step(1);
    endtask

    task automatic t_dq_wake();
        go_sleep();
        dq = 1'b1; pmod = 1'b0; step(4);
        check(active, 1'b0, "R7", "dq high with pmod=0");
        pmod = 1'b1; swen = 1'b1; step(2);
        check(active, 1'b0, "R7", "dq high with swen=1");
        swen = 1'b0; step(1);
        check(active, 1'b1, "R7", "dq high wakes with pmod=1 swen=0");
        pmod = 1'b0; dq = 1'b0; step(3);
    endtask

    task automatic t_timeout();
        go_active();
        pmod = 1'b1; dq = 1'b1; step(3);
        dq = 1'b0; step(3);
        ticks(LIMIT - 1);
        step(2);
        check(active, 1'b1, "R2", "one tick short of timeout");
        tick = 1'b1; step(1);
        tick = 1'b0; step(1);
        check(active, 1'b0, "R2", "sleep after full timeout");
        pmod = 1'b0; dq = 1'b1; step(3);
        dq = 1'b0; step(1);
    endtask

    task automatic t_no_pmod();
        go_active();
        ticks(LIMIT + 3);
        step(2);
        check(active, 1'b1, "R3", "no timeout sleep with pmod=0");
        dq = 1'b1; step(3);
        dq = 1'b0; step(1);
    endtask

    task automatic t_restart();
        go_active();
        pmod = 1'b1; dq = 1'b1; step(3);
        dq = 1'b0; step(3);
        ticks(LIMIT - 1);
        dq = 1'b1; step(3);
        dq = 1'b0; step(3);
        ticks(LIMIT - 1);
        step(2);
        check(active, 1'b1, "R4", "timer restarted by high line");
        pmod = 1'b0; dq = 1'b1; step(3);
        dq = 1'b0; step(1);
    endtask

    task automatic t_uv();
        go_active();
        ps_n = 1'b0; step(3);
        uv = 1'b1; step(1);
        uv = 1'b0; step(1);
        check(active, 1'b1, "R10", "wake beats undervoltage");
        ps_n = 1'b1; step(3);
        uv = 1'b1; step(1);
        check(active, 1'b0, "R5", "undervoltage sleeps on next edge");
        uv = 1'b0; step(1);
    endtask

    task automatic t_swap();
        go_sleep();
        swap = 1'b1; step(1);
        swap = 1'b0; step(1);
        check(active, 1'b0, "R6", "swap ignored with swen=0");
        swen = 1'b1;
        swap = 1'b1; step(1);
        check(active, 1'b1, "R6", "swap wakes with swen=1");
        swap = 1'b0; step(1);
        check(active, 1'b1, "R6", "holds after swap");
        swap = 1'b1; step(1);
        check(active, 1'b0, "R6", "swap sleeps with swen=1");
        swap = 1'b0; step(1);
        check(pls_pd, 1'b0, "R11", "no pull-down asleep with swen=1");
        swen = 1'b0; step(1);
    endtask

    initial begin : watchdog
        wait (cyc > 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        #1;
        t_reset();
        t_ps_wake();
        t_chg();
        t_dq_wake();
        t_timeout();
        t_no_pmod();
        t_restart();
        t_uv();
        t_swap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule